// File: doc/BRIEF.md
# Power-Controller Register Target with Commit-on-STOP

This block is the two-wire serial (I2C) target that fronts the command registers of a power-management controller. A bus master writes a sub-address byte and then data bytes. Each data byte lands in a shadow copy of the addressed register. The shadow copies only reach the active command latches, which drive the regulators, when a STOP condition appears on the bus. A repeated START does not count as a STOP. Because of this, several chips on the same bus can be loaded and then switched together with one final STOP.

A read has this shape: START, write address, sub-address byte, repeated START, read address, then one byte returned by the target. Eleven command registers can be read and written. Two more sub-addresses return the real-time and latched status inputs and cannot be written. One further sub-address arms an interrupt-clear command, and a following transaction completes it. The SCL and SDA inputs arrive already synchronised to the block clock. The block drives the bus only through an SDA pull-down enable.

Top module: `pmic_reg_target`

## Requirements
- R1: After reset the active latches hold 6Fh for sub-addresses 01h–04h, 0Fh for 05h–07h, 00h for 08h, 09h and 0Bh, and FFh for 0Ah. The latch for sub-address n sits in `cmdActive[8n-1 -: 8]`. `sdaPullDown` and `clearIrq` are low.
- R2: A data byte written to sub-address 01h–0Bh leaves `cmdActive` unchanged while the transaction has not ended with a STOP.
- R3: On a STOP, every staged byte is moved into its active latch in the same clock edge. This applies to any STOP seen on the bus.
- R4: A repeated START between write transactions commits nothing.
- R5: The address byte 12h (7-bit address 09h, R/W bit 0) and the address byte 13h (R/W bit 1) are acknowledged. Any other address byte is not acknowledged, and the rest of that transaction is ignored.
- R6: Sub-address bytes and data bytes for 00h, 0Ch–0Fh, and for any sub-address with bits 7..4 not all zero, are acknowledged but change no latch.
- R7: A read returns the active (committed) latch for 01h–0Bh, `statusLive` for 0Ch, `statusHeld` for 0Dh, and 00h for any other sub-address. Bits are sent MSB first.
- R8: `clearIrq` pulses high for exactly one clock after the STOP of a transaction whose last sub-address byte was 00h. The pulse happens only if the previous transaction ended by STOP had 0Fh as its last sub-address byte.
- R9: The target pulls SDA low for the acknowledge bit of every byte it accepts. It releases SDA while idle or ignoring a transaction.
- R10: When several data bytes follow one sub-address, all of them go to that same register, and the last byte is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level (wired bus value) |
| statusLive | input | 8 | Real-time status byte returned at 0Ch |
| statusHeld | input | 8 | Latched status byte returned at 0Dh |
| cmdActive | output | 88 | Active command latches, register n at bits 8n-1..8n-8 |
| sdaPullDown | output | 1 | When high, the target pulls SDA low |
| clearIrq | output | 1 | One-cycle interrupt-clear strobe |

## Verification
STOP is recognised on the first clock edge that sees SDA high while SCL stays high, and the active latches and the clear strobe change on that edge. The acknowledge pull-down and each read bit follow one clock after the SCL falling edge is seen. The bench drives the bus on falling clock edges and holds each bus phase for five clocks. It checks the latches only after a full phase has passed since a STOP or a data acknowledge, and it samples SDA in the middle of the SCL-high phase. This keeps every check well clear of the cycle in which a result changes.

// File: rtl/pmic_reg_pkg.sv
package pmic_reg_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_SKIP
  } bus_state_t;

  typedef struct packed {
    logic  shadowWr;
    logic  commit;
    byte_t wrData;
    byte_t subAddr;
  } ctrl_strobes_t;

  // reset value of the command register at sub-address idx+1
  function automatic byte_t cmdDefault(input int idx);
    if (idx < 4)       return 8'h6F;
    else if (idx < 7)  return 8'h0F;
    else if (idx == 9) return 8'hFF;
    else               return 8'h00;
  endfunction
endpackage

// File: rtl/pmic_bus_ctrl.sv
module pmic_bus_ctrl
  import pmic_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h09,
  parameter int         NUM_CMD  = 11,
  parameter byte_t      SUB_CLR  = 8'h0F,
  parameter byte_t      SUB_NONE = 8'h00
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  byte_t         rdData,
  output ctrl_strobes_t stb,
  output logic          sdaPullDown,
  output logic          clearIrq
);
  localparam logic [3:0] BITS_FULL = 4'(BYTE_W);
  localparam logic [3:0] BITS_LAST = 4'(BYTE_W - 1);

  bus_state_t state;
  logic       sclQ, sdaQ;
  logic [3:0] bitCnt;
  byte_t      shiftReg, subAddr;
  logic       rdMode, subSeen, clrArm;
  logic       sclRise, sclFall, startDet, stopDet, subValid, byteDone;

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign startDet = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign subValid = (subAddr != '0) && (int'(subAddr) <= NUM_CMD);
  assign byteDone = sclFall && (bitCnt == BITS_FULL);

  always_comb begin
    stb.shadowWr = (state == ST_WDATA) && byteDone && subValid;
    stb.commit   = stopDet;
    stb.wrData   = shiftReg;
    stb.subAddr  = subAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ        <= 1'b1;
      sdaQ        <= 1'b1;
      state       <= ST_IDLE;
      bitCnt      <= '0;
      shiftReg    <= '0;
      subAddr     <= '0;
      rdMode      <= 1'b0;
      sdaPullDown <= 1'b0;
      subSeen     <= 1'b0;
      clrArm      <= 1'b0;
      clearIrq    <= 1'b0;
    end else begin
      sclQ     <= sclIn;
      sdaQ     <= sdaIn;
      clearIrq <= 1'b0;
      if (stopDet) begin
        state       <= ST_IDLE;
        sdaPullDown <= 1'b0;
        bitCnt      <= '0;
        subSeen     <= 1'b0;
        if (subSeen && subAddr == SUB_CLR) begin
          clrArm <= 1'b1;
        end else begin
          clrArm <= 1'b0;
          if (subSeen && subAddr == SUB_NONE && clrArm) clearIrq <= 1'b1;
        end
      end else if (startDet) begin
        state       <= ST_ADDR;
        bitCnt      <= '0;
        sdaPullDown <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (sclRise && bitCnt != BITS_FULL) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
              bitCnt   <= bitCnt + 4'd1;
            end else if (byteDone) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (shiftReg[BYTE_W-1:1] == DEV_ADDR) begin
                  rdMode      <= shiftReg[0];
                  sdaPullDown <= 1'b1;
                  state       <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_SUB) begin
                subAddr     <= shiftReg;
                subSeen     <= 1'b1;
                sdaPullDown <= 1'b1;
                state       <= ST_SUB_ACK;
              end else begin
                sdaPullDown <= 1'b1;
                state       <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (rdMode) begin
                shiftReg    <= rdData;
                sdaPullDown <= ~rdData[BYTE_W-1];
                bitCnt      <= '0;
                state       <= ST_RDATA;
              end else begin
                sdaPullDown <= 1'b0;
                state       <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (sclFall) begin
              sdaPullDown <= 1'b0;
              state       <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclFall) begin
              if (bitCnt == BITS_LAST) begin
                sdaPullDown <= 1'b0;
                state       <= ST_RDATA_ACK;
              end else begin
                shiftReg    <= {shiftReg[BYTE_W-2:0], 1'b0};
                sdaPullDown <= ~shiftReg[BYTE_W-2];
                bitCnt      <= bitCnt + 4'd1;
              end
            end
          end
          ST_RDATA_ACK: if (sclFall) state <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullDown);

  // R5
  skip_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaPullDown);

  // R8
  clear_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearIrq |=> !clearIrq);

  // R8
  clear_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearIrq |-> $past(stopDet));
endmodule

// File: rtl/pmic_reg_bank.sv
module pmic_reg_bank
  import pmic_reg_pkg::*;
#(
  parameter int    NUM_CMD  = 11,
  parameter byte_t SUB_LIVE = 8'h0C,
  parameter byte_t SUB_HELD = 8'h0D
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobes_t             stb,
  input  byte_t                     statusLive,
  input  byte_t                     statusHeld,
  output byte_t                     rdData,
  output logic [NUM_CMD*BYTE_W-1:0] cmdActive
);
  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
    localparam byte_t RST_VAL = cmdDefault(i);
    byte_t shadowQ, activeQ;
    logic  pendQ, hit;

    assign hit = (stb.subAddr == byte_t'(i + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowQ <= RST_VAL;
        activeQ <= RST_VAL;
        pendQ   <= 1'b0;
      end else begin
        if (stb.shadowWr && hit) begin
          shadowQ <= stb.wrData;
          pendQ   <= 1'b1;
        end
        if (stb.commit) begin
          if (pendQ) activeQ <= shadowQ;
          pendQ <= 1'b0;
        end
      end
    end

    assign cmdActive[i*BYTE_W +: BYTE_W] = activeQ;

    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.commit |=> !pendQ);
  end

  always_comb begin
    rdData = '0;
    if (stb.subAddr == SUB_LIVE) rdData = statusLive;
    else if (stb.subAddr == SUB_HELD) rdData = statusHeld;
    else begin
      for (int k = 0; k < NUM_CMD; k++)
        if (stb.subAddr == byte_t'(k + 1)) rdData = cmdActive[k*BYTE_W +: BYTE_W];
    end
  end

  // R2
  hold_until_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(cmdActive));
endmodule

// File: rtl/pmic_reg_target.sv
module pmic_reg_target
  import pmic_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h09,
  parameter int         NUM_CMD  = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic [7:0]                statusLive,
  input  logic [7:0]                statusHeld,
  output logic [NUM_CMD*BYTE_W-1:0] cmdActive,
  output logic                      sdaPullDown,
  output logic                      clearIrq
);
  ctrl_strobes_t stb;
  byte_t         rdData;

  pmic_bus_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_CMD(NUM_CMD)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rdData(rdData),
    .stb(stb), .sdaPullDown(sdaPullDown), .clearIrq(clearIrq)
  );

  pmic_reg_bank #(.NUM_CMD(NUM_CMD)) u_bank (
    .clk(clk), .rstN(rstN), .stb(stb), .statusLive(statusLive),
    .statusHeld(statusHeld), .rdData(rdData), .cmdActive(cmdActive)
  );
endmodule

// File: tb/pmic_reg_target_tb.sv
module pmic_reg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 5;
  localparam int NCMD       = 11;

  logic clk = 1'b0, rstN = 1'b0, mScl = 1'b1, mSda = 1'b1;
  logic [7:0] statusLive = 8'h00, statusHeld = 8'h00;
  logic [NCMD*8-1:0] cmdActive;
  logic sdaPullDown, clearIrq, sdaBus;
  int checks = 0, errors = 0, clrSeen = 0, expClr = 0;
  logic [7:0] expShadow [NCMD];
  logic [7:0] expActive [NCMD];
  logic [7:0] lastSub = 8'h00;
  logic subSeenM = 1'b0, expArm = 1'b0, done = 1'b0;

  assign sdaBus = mSda & ~sdaPullDown;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (clearIrq) clrSeen++;

  pmic_reg_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .statusLive(statusLive), .statusHeld(statusHeld),
    .cmdActive(cmdActive), .sdaPullDown(sdaPullDown), .clearIrq(clearIrq)
  );

  function automatic logic [7:0] defVal(input int sub);
    if (sub <= 4) return 8'h6F;
    if (sub <= 7) return 8'h0F;
    if (sub == 10) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] sub);
    if (sub >= 8'd1 && sub <= 8'd11) return expActive[sub-1];
    if (sub == 8'h0C) return statusLive;
    if (sub == 8'h0D) return statusHeld;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic checkActive(input string req);
    for (int i = 0; i < NCMD; i++) chk(req, cmdActive[i*8 +: 8], expActive[i]);
  endtask

  task automatic busStart();
    mSda = 1'b1; mScl = 1'b1; qwait();
    mSda = 1'b0; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic busRestart();
    mSda = 1'b1; qwait();
    mScl = 1'b1; qwait();
    mSda = 1'b0; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic modelStop();
    for (int i = 0; i < NCMD; i++) expActive[i] = expShadow[i];
    if (subSeenM && lastSub == 8'h0F) expArm = 1'b1;
    else begin
      if (subSeenM && lastSub == 8'h00 && expArm) expClr++;
      expArm = 1'b0;
    end
    subSeenM = 1'b0;
  endtask

  task automatic busStop();
    mSda = 1'b0; qwait();
    mScl = 1'b1; qwait();
    mSda = 1'b1; qwait();
    modelStop();
  endtask

  task automatic sendBit(input logic b);
    mSda = b; qwait();
    mScl = 1'b1; qwait(); qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; qwait();
    mScl = 1'b1; qwait();
    b = sdaBus; qwait();
    mScl = 1'b0; qwait();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    getBit(b);
    ack = ~b;
  endtask

  task automatic getByte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    sendBit(nack);
  endtask

  task automatic wrSub(input logic [7:0] sub);
    logic ack;
    sendByte(8'h12, ack);
    chk("R5 write address ack", ack, 1);
    sendByte(sub, ack);
    chk("R9 sub-address ack", ack, 1);
    lastSub = sub; subSeenM = 1'b1;
  endtask

  task automatic wrData(input logic [7:0] d);
    logic ack;
    sendByte(d, ack);
    chk("R6 data ack", ack, 1);
    if (lastSub >= 8'd1 && lastSub <= 8'd11) expShadow[lastSub-1] = d;
  endtask

  task automatic readReg(input logic [7:0] sub, input string req);
    logic ack;
    logic [7:0] d;
    busStart();
    wrSub(sub);
    busRestart();
    sendByte(8'h13, ack);
    chk("R5 read address ack", ack, 1);
    getByte(d, 1'b1);
    chk(req, d, expRead(sub));
    busStop();
  endtask

  function automatic logic [7:0] pickSub();
    int r = int'($urandom % 8);
    if (r < 6) return 8'(1 + $urandom % 11);
    if (r == 6) return 8'($urandom % 16);
    return 8'($urandom % 256);
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    int clrBase;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NCMD; i++) begin
      expShadow[i] = defVal(i + 1);
      expActive[i] = expShadow[i];
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    checkActive("R1 reset defaults");
    chk("R1 pull-down idle", sdaPullDown, 0);
    chk("R1 clear idle", clearIrq, 0);

    // R2 / R3: staged then committed
    busStart(); wrSub(8'h03); wrData(8'hA5);
    chk("R2 held before stop", cmdActive[23:16], 8'h6F);
    checkActive("R2 unchanged before stop");
    busStop();
    checkActive("R3 committed on stop");

    // R4: repeated START commits nothing
    busStart(); wrSub(8'h05); wrData(8'h3C);
    busRestart(); wrSub(8'h07); wrData(8'h81);
    chk("R4 no commit on restart", cmdActive[39:32], 8'h0F);
    busStop();
    checkActive("R4 commit after final stop");

    // R10: last of several data bytes wins
    busStart(); wrSub(8'h09); wrData(8'h11); wrData(8'h22); busStop();
    chk("R10 last byte kept", cmdActive[71:64], 8'h22);

    // R6: rejected sub-addresses
    busStart(); wrSub(8'h00); wrData(8'h55); busStop();
    busStart(); wrSub(8'h0C); wrData(8'h55); busStop();
    busStart(); wrSub(8'h0D); wrData(8'h55); busStop();
    busStart(); wrSub(8'h0E); wrData(8'h55); busStop();
    busStart(); wrSub(8'h21); wrData(8'h55); busStop();
    busStart(); wrSub(8'h1B); wrData(8'h55); busStop();
    checkActive("R6 invalid sub discarded");

    // R5: foreign address ignored
    busStart();
    sendByte(8'h22, ack); chk("R5 foreign address nack", ack, 0);
    sendByte(8'h04, ack); chk("R5 ignored byte nack", ack, 0);
    sendByte(8'h99, ack); chk("R5 ignored data nack", ack, 0);
    busStop();
    checkActive("R5 foreign write no effect");
    chk("R9 released after stop", sdaPullDown, 0);

    // R7: reads
    statusLive = 8'h5A; statusHeld = 8'hC3;
    readReg(8'h03, "R7 read command");
    readReg(8'h0A, "R7 read default FF");
    readReg(8'h0C, "R7 read live status");
    readReg(8'h0D, "R7 read held status");
    readReg(8'h0E, "R7 read invalid zero");
    readReg(8'h43, "R7 read upper nibble zero");

    // R8: clear-interrupt sequence
    clrBase = clrSeen;
    busStart(); wrSub(8'h0F); busStop();
    chk("R8 no pulse on arm", clrSeen, clrBase);
    busStart(); wrSub(8'h00); busStop();
    chk("R8 pulse on 00h after 0Fh", clrSeen, clrBase + 1);
    busStart(); wrSub(8'h00); busStop();
    chk("R8 no pulse unarmed", clrSeen, clrBase + 1);
    busStart(); wrSub(8'h0F); busStop();
    busStart(); wrSub(8'h02); wrData(8'h77); busStop();
    busStart(); wrSub(8'h00); busStop();
    chk("R8 arm cancelled", clrSeen, clrBase + 1);
    chk("R8 model agrees", clrSeen, expClr);

    // random traffic
    statusLive = 8'($urandom); statusHeld = 8'($urandom);
    for (int it = 0; it < 25; it++) begin
      int nTx = 1 + int'($urandom % 3);
      busStart();
      for (int t = 0; t < nTx; t++) begin
        int nd = 1 + int'($urandom % 2);
        if (t > 0) busRestart();
        wrSub(pickSub());
        for (int d = 0; d < nd; d++) wrData(8'($urandom));
      end
      checkActive("R2 random staged");
      busStop();
      checkActive("R3 random committed");
      readReg(pickSub(), "R7 random read");
    end
    chk("R8 random clear count", clrSeen, expClr);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule